// File: doc/BRIEF.md
# Sliced Wide RAM Bridge

This block puts a RAM whose entries may be much wider than 16 bits behind a 16-bit register bus. Each entry is stored as a row of 16-bit slices placed side by side, and each slice is a RAM of its own. The bus side sees the slices one after another in a flat address window that starts at a base address. Bus address offset k selects entry k / S and slice k mod S, where S is the number of slices per entry. Slice 0 holds the least significant bits.

The second port is a native user port at the full entry width, so user logic can read or write a whole entry in one cycle. Both ports share one clock. A host that fills a wide entry over the bus needs one bus write per slice. Between those writes the entry holds a mix of old and new slices.

Only the entry width, the depth and the base address are parameters. The slice count, the address widths and the masking of the top slice are all derived from them.

Top module: `wide_ram_bridge`

## Requirements
- R1: A bus read (`bus_re` high with an in-range address) returns the addressed slice on `bus_rdata` exactly one clock after the request. A read that coincides with a write to the same slice returns the old contents.
- R2: Bus offset k = `bus_addr` - BASE_ADDR selects entry k / S and slice k mod S, with S = ceil(ENTRY_W/16). Slice j holds entry bits [16j+15:16j], lowest slice first. For a 34-bit entry, offsets 0, 1 and 2 are bits [15:0], [31:16] and [33:32] of entry 0, and offset 3 is bits [15:0] of entry 1.
- R3: In the top slice, write-data bits above the entry width are dropped. The same bits read back as zero on `bus_rdata`.
- R4: A bus write changes only the addressed slice of the addressed entry. All other bits of that entry keep their values.
- R5: Bus accesses to addresses below BASE_ADDR or at or above BASE_ADDR + DEPTH*S change no stored bit. A read of such an address gives `bus_rdata` = 0 in the following cycle.
- R6: In any cycle after a clock edge where `bus_re` was low, `bus_rdata` is 0.
- R7: When `usr_we` is high, the user port writes the whole entry at `usr_addr`. `usr_rdata` shows the entry at `usr_addr` one clock after the address is presented, and reads return the old contents when a write hits the same entry.
- R8: Data written through either port can be read back through the other port.
- R9: When the user port and the bus write the same entry in the same cycle, the user data wins in every slice.
- R10: While `rst` is high and in the cycle after it is released, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the bus read path |
| bus_addr | input | 16 | Bus word address |
| bus_wdata | input | 16 | Bus write data for one slice |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 16 | Bus read data, one clock after `bus_re` |
| usr_addr | input | clog2(DEPTH) | User entry index |
| usr_wdata | input | ENTRY_W | User write data, full entry |
| usr_we | input | 1 | User write enable |
| usr_rdata | output | ENTRY_W | User read data, one clock after `usr_addr` |

## Verification
Some rules are checked by the assertions on every cycle. They cover:
- the zero read-back for idle cycles and for out-of-range addresses;
- the zero padding of the top slice;
- the decoded entry and slice staying in range;
- at most one slice receiving a bus write strobe.

Other behaviour can only be shown by the bench's scenarios. These are the slice ordering, the preservation of neighbouring slices, the dropping of out-of-window writes, cross-port visibility and the collision priority. For them, a behavioural model of the whole memory predicts both read ports on every clock, and directed checks pin down the 34-bit layout.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int unsigned BUS_W = 16;

  // number of bus-width slices needed to hold one entry
  function automatic int unsigned slice_count(int unsigned width);
    return (width + BUS_W - 1) / BUS_W;
  endfunction

  // index width, never below one bit
  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wrb_addr_decode.sv
module wrb_addr_decode #(
  parameter logic [15:0] BASE_ADDR = 16'h0100,
  parameter int unsigned SLICES    = 3,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned EIDX_W    = 4,
  parameter int unsigned SIDX_W    = 2
) (
  input  logic [15:0]       addr,
  output logic              hit,
  output logic [EIDX_W-1:0] entry,
  output logic [SIDX_W-1:0] slice
);
  localparam int unsigned SPAN = DEPTH * SLICES;

  logic [16:0] offset;
  logic [16:0] ent_full;
  logic [16:0] sl_full;

  always_comb begin
    offset   = {1'b0, addr} - {1'b0, BASE_ADDR};
    hit      = (addr >= BASE_ADDR) && (offset < 17'(SPAN));
    ent_full = offset / 17'(SLICES);
    sl_full  = offset % 17'(SLICES);
    entry    = EIDX_W'(ent_full);
    slice    = SIDX_W'(sl_full);
  end
endmodule

// File: rtl/wrb_slice_ram.sv
module wrb_slice_ram #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  // read-first on both ports; port B is written last so it wins a collision
  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/wide_ram_bridge.sv
module wide_ram_bridge
  import wrb_pkg::*;
#(
  parameter int unsigned ENTRY_W   = 34,
  parameter int unsigned DEPTH     = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0100,
  localparam int unsigned AW       = idx_w(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        bus_addr,
  input  logic [15:0]        bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [15:0]        bus_rdata,
  input  logic [AW-1:0]      usr_addr,
  input  logic [ENTRY_W-1:0] usr_wdata,
  input  logic               usr_we,
  output logic [ENTRY_W-1:0] usr_rdata
);
  localparam int unsigned SLICES = slice_count(ENTRY_W);
  localparam int unsigned SW     = idx_w(SLICES);
  localparam int unsigned TOP_W  = ENTRY_W - BUS_W * (SLICES - 1);
  localparam int unsigned SPAN   = DEPTH * SLICES;

  logic              hit;
  logic [AW-1:0]     ent;
  logic [SW-1:0]     sl;
  logic [SLICES-1:0] slice_we;
  logic [15:0]       slice_rd [SLICES];
  logic              rd_hit_q;
  logic [SW-1:0]     rd_sl_q;

  wrb_addr_decode #(
    .BASE_ADDR(BASE_ADDR), .SLICES(SLICES), .DEPTH(DEPTH),
    .EIDX_W(AW), .SIDX_W(SW)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .entry(ent), .slice(sl)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int unsigned W  = (s == SLICES - 1) ? TOP_W : BUS_W;
    localparam int unsigned LO = s * BUS_W;
    logic [W-1:0] a_q;

    assign slice_we[s] = bus_we && hit && (sl == SW'(s));

    wrb_slice_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk    (clk),
      .a_we   (slice_we[s]),
      .a_addr (ent),
      .a_wdata(bus_wdata[W-1:0]),
      .a_rdata(a_q),
      .b_we   (usr_we),
      .b_addr (usr_addr),
      .b_wdata(usr_wdata[LO+W-1:LO]),
      .b_rdata(usr_rdata[LO+W-1:LO])
    );

    // unused upper bits of the top slice read as zero
    assign slice_rd[s] = 16'(a_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit_q <= 1'b0;
      rd_sl_q  <= '0;
    end else begin
      rd_hit_q <= bus_re && hit;
      rd_sl_q  <= sl;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit_q) bus_rdata = slice_rd[rd_sl_q];
  end

  // R5: below the window nothing is returned
  p_low_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (bus_addr < BASE_ADDR)) |=> (bus_rdata == 16'h0));

  // R5: above the window nothing is returned
  p_high_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_re && ({1'b0, bus_addr} >= ({1'b0, BASE_ADDR} + 17'(SPAN)))) |=> (bus_rdata == 16'h0));

  // R6: no read request, no read data
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == 16'h0));

  // R4: a bus write reaches at most one slice RAM
  p_one_slice_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slice_we));

  // R2: a decoded hit always lands inside the array
  p_decode_range_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((32'(ent) < DEPTH) && (32'(sl) < SLICES)));

  if (TOP_W < BUS_W) begin : g_pad_chk
    // R3: padding bits of the top slice read back as zero
    p_top_pad_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_re && hit && (sl == SW'(SLICES - 1))) |=> (bus_rdata[15:TOP_W] == '0));
  end
endmodule

// File: tb/wide_ram_bridge_tb.sv
module wide_ram_bridge_tb;
  localparam int unsigned ENTRY_W   = 34;
  localparam int unsigned DEPTH     = 16;
  localparam logic [15:0] BASE      = 16'h0100;
  localparam int unsigned S         = (ENTRY_W + 15) / 16;
  localparam int unsigned AW        = $clog2(DEPTH);
  localparam int          CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [15:0]        bus_addr = '0;
  logic [15:0]        bus_wdata = '0;
  logic               bus_we = 1'b0;
  logic               bus_re = 1'b0;
  logic [15:0]        bus_rdata;
  logic [AW-1:0]      usr_addr = '0;
  logic [ENTRY_W-1:0] usr_wdata = '0;
  logic               usr_we = 1'b0;
  logic [ENTRY_W-1:0] usr_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit summary_done = 1'b0;
  string phase = "R10";

  wide_ram_bridge #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata),
    .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_we(usr_we), .usr_rdata(usr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [ENTRY_W-1:0] model [DEPTH];
  bit                 known [DEPTH];
  logic [15:0]        exp_bus = '0;
  logic [ENTRY_W-1:0] exp_usr = '0;
  bit                 exp_usr_known = 1'b0;

  function automatic bit in_window(logic [15:0] a, output int e, output int s);
    int off;
    off = int'(a) - int'(BASE);
    e = 0; s = 0;
    if (off < 0 || off >= int'(DEPTH * S)) return 1'b0;
    e = off / S;
    s = off % S;
    return 1'b1;
  endfunction

  function automatic logic [15:0] slice_of(logic [ENTRY_W-1:0] v, int s);
    logic [15:0] r;
    r = '0;
    for (int b = 0; b < 16; b++)
      if (s * 16 + b < ENTRY_W) r[b] = v[s * 16 + b];
    return r;
  endfunction

  always @(posedge clk) begin
    int e, s;
    bit inr;
    if (rst) begin
      exp_bus = '0;
      exp_usr_known = 1'b0;
    end else begin
      inr = in_window(bus_addr, e, s);
      exp_bus = (bus_re && inr) ? slice_of(model[e], s) : 16'h0;
      exp_usr_known = known[usr_addr];
      exp_usr = model[usr_addr];
      if (bus_we && inr)
        for (int b = 0; b < 16; b++)
          if (s * 16 + b < ENTRY_W) model[e][s * 16 + b] = bus_wdata[b];
      if (usr_we) begin
        model[usr_addr] = usr_wdata;
        known[usr_addr] = 1'b1;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !summary_done) begin
      chk(bus_rdata === exp_bus, phase, 64'(bus_rdata), 64'(exp_bus));
      if (exp_usr_known)
        chk(usr_rdata === exp_usr, phase, 64'(usr_rdata), 64'(exp_usr));
    end
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      summary();
    end
  end

  // ---------------- stimulus tasks (called at negedge) ----------------
  task automatic step();
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0; usr_we = 1'b0;
  endtask

  task automatic bus_wr(logic [15:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
  endtask

  task automatic bus_rd(logic [15:0] a);
    bus_addr = a; bus_re = 1'b1;
    step();
  endtask

  task automatic usr_wr(int e, logic [ENTRY_W-1:0] d);
    usr_addr = AW'(e); usr_wdata = d; usr_we = 1'b1;
    step();
  endtask

  task automatic usr_rd(int e);
    usr_addr = AW'(e);
    step();
  endtask

  function automatic logic [ENTRY_W-1:0] init_val(int e);
    return ENTRY_W'(e) * 34'h0_0301_0107 + 34'h2_4000_0011;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      known[i] = 1'b0;
      model[i] = '0;
    end
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    chk(bus_rdata == 16'h0, "R10", 64'(bus_rdata), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_rdata == 16'h0, "R10", 64'(bus_rdata), 64'h0);

    phase = "R7";
    for (int i = 0; i < DEPTH; i++) usr_wr(i, init_val(i));
    usr_rd(7);
    chk(usr_rdata === init_val(7), "R7", 64'(usr_rdata), 64'(init_val(7)));
    usr_wr(7, 34'h1_2345_6789);
    usr_rd(7);
    chk(usr_rdata === 34'h1_2345_6789, "R7", 64'(usr_rdata), 64'h1_2345_6789);

    phase = "R2";
    bus_wr(BASE + 16'd0, 16'h1234);
    bus_wr(BASE + 16'd1, 16'h5678);
    phase = "R3";
    bus_wr(BASE + 16'd2, 16'hFFFF);
    usr_rd(0);
    chk(usr_rdata === 34'h3_5678_1234, "R2", 64'(usr_rdata), 64'h3_5678_1234);
    bus_rd(BASE + 16'd2);
    chk(bus_rdata === 16'h0003, "R3", 64'(bus_rdata), 64'h3);
    phase = "R1";
    bus_rd(BASE + 16'd1);
    chk(bus_rdata === 16'h5678, "R1", 64'(bus_rdata), 64'h5678);
    phase = "R2";
    bus_wr(BASE + 16'd3, 16'hBEEF);
    usr_rd(1);
    chk(usr_rdata[15:0] === 16'hBEEF, "R2", 64'(usr_rdata[15:0]), 64'hBEEF);

    phase = "R4";
    usr_wr(5, 34'h2_AAAA_5555);
    bus_wr(BASE + 16'(5 * S + 1), 16'h1111);
    usr_rd(5);
    chk(usr_rdata === 34'h2_1111_5555, "R4", 64'(usr_rdata), 64'h2_1111_5555);

    phase = "R5";
    bus_wr(BASE - 16'd1, 16'hDEAD);
    bus_wr(BASE + 16'(DEPTH * S), 16'hDEAD);
    usr_rd(0);
    chk(usr_rdata === 34'h3_5678_1234, "R5", 64'(usr_rdata), 64'h3_5678_1234);
    usr_rd(DEPTH - 1);
    chk(usr_rdata === init_val(DEPTH - 1), "R5", 64'(usr_rdata), 64'(init_val(DEPTH - 1)));
    bus_rd(BASE - 16'd1);
    chk(bus_rdata === 16'h0, "R5", 64'(bus_rdata), 64'h0);
    bus_rd(BASE + 16'(DEPTH * S));
    chk(bus_rdata === 16'h0, "R5", 64'(bus_rdata), 64'h0);

    phase = "R6";
    bus_addr = BASE;
    step();
    chk(bus_rdata === 16'h0, "R6", 64'(bus_rdata), 64'h0);

    phase = "R8";
    usr_wr(9, 34'h1_CAFE_F00D);
    bus_rd(BASE + 16'(9 * S + 1));
    chk(bus_rdata === 16'hCAFE, "R8", 64'(bus_rdata), 64'hCAFE);
    bus_rd(BASE + 16'(9 * S + 2));
    chk(bus_rdata === 16'h0001, "R8", 64'(bus_rdata), 64'h1);

    phase = "R9";
    usr_addr = AW'(10); usr_wdata = 34'h0_0000_0001; usr_we = 1'b1;
    bus_addr = BASE + 16'(10 * S); bus_wdata = 16'h7777; bus_we = 1'b1;
    step();
    usr_rd(10);
    chk(usr_rdata === 34'h0_0000_0001, "R9", 64'(usr_rdata), 64'h1);

    phase = "R1";
    for (int n = 0; n < 400; n++) begin
      bus_addr  = BASE - 16'd4 + 16'($urandom_range(0, DEPTH * S + 8));
      bus_wdata = 16'($urandom);
      bus_we    = 1'($urandom_range(0, 2) == 0);
      bus_re    = 1'($urandom_range(0, 1));
      usr_addr  = AW'($urandom_range(0, DEPTH - 1));
      usr_wdata = {2'($urandom), 32'($urandom)};
      usr_we    = 1'($urandom_range(0, 3) == 0);
      step();
    end
    step();
    summary();
  end
endmodule